// File: doc/BRIEF.md
# Multi-level machine timer comparator

This block keeps one 64-bit time base and compares it against three compare levels: machine, supervisor and virtual supervisor. The counter advances by one on every tick of a programmable prescaler, and it wraps from all-ones to zero. The machine and supervisor levels compare the counter itself. The virtual level first adds a 64-bit guest offset to the counter, with the sum truncated to 64 bits, and compares that. Each level drives a level-sensitive pending output. Each output is computed combinationally from the current register contents, so it always reflects the latest counter, compare and offset values.

Software reaches the counter, the three compare registers, the guest offset and the prescaler through a word-addressed register bus with valid/ready request and response channels. No separate time register exists: the supervisor and virtual comparisons read the same counter that software writes. A write to that counter therefore retimes all three levels in the same cycle. A write and a tick in the same cycle resolve in favour of the write.

The request channel is accepted on a cycle where `req_valid` and `req_ready` are both high. Writes produce no response. A read produces one response beat, which is held stable until `rsp_ready` is high. While that beat is outstanding, `req_ready` stays low, so a slow reader back-pressures every further request, writes included.

Top module: `mlt_timer`

## Requirements
- R1: After reset the counter, the guest offset and the prescaler divisor are zero, all three compare registers read as all-ones, and no pending output is high.
- R2: With prescaler value P, the counter gains exactly one every P+1 clock cycles. Writing the prescaler restarts its division from zero, so the first increment lands on the (P+1)-th edge after the write edge. The value all-ones at word 10 effectively stops the counter.
- R3: The counter wraps from all-ones to zero on a tick.
- R4: The machine pending output is high exactly when the counter is greater than or equal to the machine compare value, as an unsigned comparison.
- R5: The supervisor pending output is high exactly when the counter is greater than or equal to the supervisor compare value, unsigned. A compare value with bit 63 set is not treated as negative.
- R6: The virtual pending output is high exactly when (counter + guest offset) mod 2^64 is greater than or equal to the virtual compare value, unsigned.
- R7: After the clock edge that takes a counter write, all three pending outputs reflect the new counter value.
- R8: Each 64-bit register is accessed as two 32-bit words: the low word at the even offset and the high word at the next offset. The offsets are: counter 0/1, machine compare 2/3, supervisor compare 4/5, virtual compare 6/7, guest offset 8/9. The prescaler is at offset 10. A write to one word leaves the other word unchanged and takes effect on the next clock edge.
- R9: When a counter write and a tick fall in the same cycle, the counter takes the written value and that cycle's increment is lost.
- R10: A read response stays valid with stable data until `rsp_ready` is high. While a response is pending, `req_ready` is low and no request is accepted. A request held through the stall is accepted afterwards.
- R11: Raising a compare value above the relevant time clears that pending output on the edge after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Reader accepts the response |
| rsp_rdata | output | 32 | Read data |
| m_pend | output | 1 | Machine timer pending |
| s_pend | output | 1 | Supervisor timer pending |
| v_pend | output | 1 | Virtual supervisor timer pending |

## Verification
The hardest case to reach from the ports is a counter write that lands on exactly the same edge as a prescaler tick. The stimulus first stops the counter with the largest divisor, then sets the divisor to zero so that every edge ticks, and then issues the counter write on the very next edge. Compare values sit one and two above the written value, so a lost or a kept increment shows up as the machine pending output rising one cycle apart. Comparisons under a running counter rely on a similar step: the divisor is written at a known edge, and pending edges are counted from there.

// File: rtl/mlt_timer_pkg.sv
package mlt_timer_pkg;
  // compare levels, in order of their index
  localparam int unsigned LVL_MACH = 0;
  localparam int unsigned LVL_SUP  = 1;
  localparam int unsigned LVL_VIRT = 2;
  localparam int unsigned NUM_LVL  = 3;

  // 64-bit register slots (word offset / 2)
  localparam int unsigned SLOT_TIME  = 0;
  localparam int unsigned SLOT_CMP0  = 1;
  localparam int unsigned SLOT_DELTA = SLOT_CMP0 + NUM_LVL;
  localparam int unsigned SLOT_PRESC = SLOT_DELTA + 1;
endpackage

// File: rtl/mlt_timer_prescaler.sv
module mlt_timer_prescaler #(
  parameter int unsigned PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] divisor,
  input  logic          restart,
  output logic          tick
);
  logic [PW-1:0] div_q;

  assign tick = (div_q == divisor);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (restart || tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/mlt_timer_counter.sv
module mlt_timer_counter #(
  parameter int unsigned TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_val,
  output logic [TW-1:0] time_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
    end else if (wr_en) begin
      time_q <= wr_val;          // a write beats a coincident tick
    end else if (tick) begin
      time_q <= time_q + 1'b1;   // wraps naturally
    end
  end
endmodule

// File: rtl/mlt_timer_cmp.sv
module mlt_timer_cmp #(
  parameter int unsigned TW = 64
) (
  input  logic [TW-1:0] time_i,
  input  logic [TW-1:0] ofs_i,
  input  logic [TW-1:0] cmp_i,
  output logic          pend_o
);
  logic [TW-1:0] view;

  assign view   = time_i + ofs_i;  // truncated to TW bits
  assign pend_o = (view >= cmp_i);
endmodule

// File: rtl/mlt_timer_regs.sv
module mlt_timer_regs
  import mlt_timer_pkg::*;
#(
  parameter int unsigned BW = 32,
  parameter int unsigned AW = 4,
  parameter int unsigned PW = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_we,
  input  logic [AW-1:0]                 req_addr,
  input  logic [BW-1:0]                 req_wdata,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [BW-1:0]                 rsp_rdata,
  input  logic [2*BW-1:0]               time_i,
  output logic                          cnt_wr_en,
  output logic [2*BW-1:0]               cnt_wr_val,
  output logic [NUM_LVL-1:0][2*BW-1:0]  cmp_o,
  output logic [2*BW-1:0]               delta_o,
  output logic [PW-1:0]                 presc_o,
  output logic                          presc_wr
);
  localparam int unsigned TW = 2 * BW;
  localparam int unsigned SW = AW - 1;

  logic          acc, wr, rd, hi;
  logic [SW-1:0] slot;
  logic [BW-1:0] rd_word;
  logic          rsp_valid_q;
  logic [BW-1:0] rsp_rdata_q;
  logic [TW-1:0] delta_q;
  logic [PW-1:0] presc_q;
  logic [NUM_LVL-1:0][TW-1:0] cmp_q;

  function automatic logic [TW-1:0] merge(input logic [TW-1:0] old,
                                          input logic [BW-1:0] d,
                                          input logic          upper);
    return upper ? {d, old[BW-1:0]} : {old[TW-1:BW], d};
  endfunction

  function automatic logic [BW-1:0] half(input logic [TW-1:0] v,
                                         input logic          upper);
    return upper ? v[TW-1:BW] : v[BW-1:0];
  endfunction

  assign req_ready = !rsp_valid_q;
  assign acc       = req_valid && req_ready;
  assign wr        = acc && req_we;
  assign rd        = acc && !req_we;
  assign slot      = req_addr[AW-1:1];
  assign hi        = req_addr[0];

  // counter write path: the counter itself lives in its own module
  assign cnt_wr_en  = wr && (slot == SW'(SLOT_TIME));
  assign cnt_wr_val = merge(time_i, req_wdata, hi);
  assign presc_wr   = wr && (slot == SW'(SLOT_PRESC)) && !hi;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q[l] <= '1;
      end else if (wr && (slot == SW'(SLOT_CMP0 + l))) begin
        cmp_q[l] <= merge(cmp_q[l], req_wdata, hi);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delta_q <= '0;
      presc_q <= '0;
    end else begin
      if (wr && (slot == SW'(SLOT_DELTA))) begin
        delta_q <= merge(delta_q, req_wdata, hi);
      end
      if (presc_wr) begin
        presc_q <= PW'(req_wdata);
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (slot == SW'(SLOT_TIME)) begin
      rd_word = half(time_i, hi);
    end else if (slot == SW'(SLOT_DELTA)) begin
      rd_word = half(delta_q, hi);
    end else if (slot == SW'(SLOT_PRESC)) begin
      rd_word = hi ? '0 : BW'(presc_q);
    end else begin
      for (int l = 0; l < NUM_LVL; l++) begin
        if (slot == SW'(SLOT_CMP0 + l)) begin
          rd_word = half(cmp_q[l], hi);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (rd) begin
      rsp_valid_q <= 1'b1;
      rsp_rdata_q <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
  assign cmp_o     = cmp_q;
  assign delta_o   = delta_q;
  assign presc_o   = presc_q;
endmodule

// File: rtl/mlt_timer.sv
module mlt_timer
  import mlt_timer_pkg::*;
#(
  parameter int unsigned BW = 32,
  parameter int unsigned AW = 4,
  parameter int unsigned PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [BW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [BW-1:0] rsp_rdata,
  output logic          m_pend,
  output logic          s_pend,
  output logic          v_pend
);
  localparam int unsigned TW = 2 * BW;

  logic                       tick;
  logic                       cnt_wr_en;
  logic [TW-1:0]              cnt_wr_val;
  logic [TW-1:0]              time_q;
  logic [NUM_LVL-1:0][TW-1:0] cmp_q;
  logic [TW-1:0]              delta_q;
  logic [PW-1:0]              presc_q;
  logic                       presc_wr;
  logic [NUM_LVL-1:0]         pend;

  mlt_timer_regs #(.BW(BW), .AW(AW), .PW(PW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_we     (req_we),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata),
    .time_i     (time_q),
    .cnt_wr_en  (cnt_wr_en),
    .cnt_wr_val (cnt_wr_val),
    .cmp_o      (cmp_q),
    .delta_o    (delta_q),
    .presc_o    (presc_q),
    .presc_wr   (presc_wr)
  );

  mlt_timer_prescaler #(.PW(PW)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .divisor (presc_q),
    .restart (presc_wr),
    .tick    (tick)
  );

  mlt_timer_counter #(.TW(TW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .wr_en  (cnt_wr_en),
    .wr_val (cnt_wr_val),
    .time_q (time_q)
  );

  // every level reads the same counter, so one write retimes them all
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [TW-1:0] ofs;
    if (l == LVL_VIRT) begin : g_guest
      assign ofs = delta_q;
    end else begin : g_host
      assign ofs = '0;
    end
    mlt_timer_cmp #(.TW(TW)) u_cmp (
      .time_i (time_q),
      .ofs_i  (ofs),
      .cmp_i  (cmp_q[l]),
      .pend_o (pend[l])
    );
  end

  assign m_pend = pend[LVL_MACH];
  assign s_pend = pend[LVL_SUP];
  assign v_pend = pend[LVL_VIRT];
endmodule

// File: rtl/mlt_timer_chk.sv
module mlt_timer_chk #(
  parameter int unsigned TW = 64,
  parameter int unsigned BW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [BW-1:0] rsp_rdata,
  input logic          tick,
  input logic          cnt_wr_en,
  input logic [TW-1:0] cnt_wr_val,
  input logic [TW-1:0] time_q,
  input logic [TW-1:0] mcmp,
  input logic          m_pend,
  input logic          s_pend,
  input logic          v_pend
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !m_pend && !s_pend && !v_pend);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R10
  req_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cnt_wr_en |=> time_q == $past(time_q) + 1'b1);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !cnt_wr_en |=> $stable(time_q));

  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> time_q == $past(cnt_wr_val));

  // R4
  mach_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(time_q) && $stable(mcmp) |-> $stable(m_pend));
endmodule

bind mlt_timer mlt_timer_chk #(.TW(TW), .BW(BW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .tick       (tick),
  .cnt_wr_en  (cnt_wr_en),
  .cnt_wr_val (cnt_wr_val),
  .time_q     (time_q),
  .mcmp       (cmp_q[0]),
  .m_pend     (m_pend),
  .s_pend     (s_pend),
  .v_pend     (v_pend)
);

// File: tb/mlt_timer_bench.sv
module mlt_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        m_pend, s_pend, v_pend;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mlt_timer u_mlt_timer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .m_pend(m_pend), .s_pend(s_pend), .v_pend(v_pend)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic wr(input int a, input logic [31:0] d);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 4'(a); req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic wr64(input int a, input logic [63:0] d);
    wr(a, d[31:0]);
    wr(a + 1, d[63:32]);
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 4'(a);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
    @(negedge clk);
  endtask

  task automatic stop_counter();
    wr(10, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 m_pend", m_pend, 0);
    chk("R1 s_pend", s_pend, 0);
    chk("R1 v_pend", v_pend, 0);
    rd(1, d);  chk("R1 time hi", d, 0);
    rd(2, d);  chk("R1 mcmp lo", d, 32'hFFFF_FFFF);
    rd(7, d);  chk("R1 vcmp hi", d, 32'hFFFF_FFFF);
    rd(8, d);  chk("R1 delta lo", d, 0);
    rd(10, d); chk("R1 prescale", d, 0);
    rd(0, d);  chk("R1 time lo small", d < 64, 1);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    stop_counter();
    wr64(0, 64'hFFFF_FFFF_FFFF_FFFF);
    wr64(2, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R3 pend at all-ones", m_pend, 1);
    wr(10, 0);
    chk("R3 no tick on divisor write edge", m_pend, 1);
    @(negedge clk);
    chk("R3 wrapped to zero", m_pend, 0);
    stop_counter();
    rd(1, d);
    chk("R3 high word after wrap", d, 0);
  endtask

  task automatic t_rate();
    logic [31:0] d;
    stop_counter();
    wr64(0, 64'd100);
    wr64(2, 64'd102);
    wr(10, 3);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 3) chk("R2 no step before period", m_pend, 0);
      if (k == 7) chk("R2 one step after 7 edges", m_pend, 0);
      if (k == 8) chk("R2 two steps after 8 edges", m_pend, 1);
    end
    stop_counter();
    rd(0, d);
    chk("R2 count at divide-by-4", d, 102);
  endtask

  task automatic t_levels();
    stop_counter();
    wr64(0, 64'd1000);
    wr64(2, 64'd1000);  chk("R4 equal pends", m_pend, 1);
    wr(2, 1001);        chk("R11 raised compare clears", m_pend, 0);
    wr(2, 999);         chk("R4 below pends", m_pend, 1);
    wr64(4, 64'd1000);  chk("R5 equal pends", s_pend, 1);
    wr(5, 32'h8000_0000); chk("R5 unsigned top bit", s_pend, 0);
    wr64(4, 64'd0);     chk("R5 zero compare", s_pend, 1);
    wr64(8, 64'hFFFF_FFFF_FFFF_FE0C);
    wr64(6, 64'd500);   chk("R6 wrapped sum equal", v_pend, 1);
    wr(6, 501);         chk("R6 wrapped sum below", v_pend, 0);
  endtask

  task automatic t_retime();
    logic [31:0] d;
    wr64(2, 64'd2000);
    wr64(4, 64'd3000);
    wr64(6, 64'd3500);
    chk("R7 none before", {m_pend, s_pend, v_pend}, 3'b000);
    wr(0, 4000);
    chk("R7 all raise on time write", {m_pend, s_pend, v_pend}, 3'b111);
    wr(0, 1999);
    chk("R7 all drop on time write", {m_pend, s_pend, v_pend}, 3'b000);
    wr(1, 5);
    rd(0, d); chk("R8 low word kept", d, 1999);
    rd(1, d); chk("R8 high word written", d, 5);
    rd(9, d); chk("R8 delta high word", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_collide();
    wr(1, 0);
    wr(0, 32'h10);
    wr64(2, 64'h52);
    wr(10, 0);
    wr(0, 32'h50);   // lands on an edge where a tick also fires
    chk("R9 written value wins", m_pend, 0);
    @(negedge clk);
    chk("R9 one step after write", m_pend, 0);
    @(negedge clk);
    chk("R9 two steps after write", m_pend, 1);
    stop_counter();
  endtask

  task automatic t_backpressure();
    logic [31:0] d;
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_we = 1'b0; req_addr = 4'd2;
    @(posedge clk);
    @(negedge clk);
    chk("R10 response raised", rsp_valid, 1);
    chk("R10 response data", rsp_rdata, 32'h52);
    req_we = 1'b1; req_wdata = 32'h99;  // held write during the stall
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 request blocked", req_ready, 0);
      chk("R10 data held", {rsp_valid, rsp_rdata}, {1'b1, 32'h52});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10 response drained", {rsp_valid, req_ready}, 2'b01);
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    rd(2, d);
    chk("R10 held write taken", d, 32'h99);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wrap();
    t_rate();
    t_levels();
    t_retime();
    t_collide();
    t_backpressure();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule